// File: doc/BRIEF.md
# Control-Flow Successor Checker

This block sits beside a processor and observes, without taking part in execution, the stream of node identifiers the processor reports as it enters each node of its program control-flow graph. Before a run, a successor table is loaded: for each node it holds up to four identifiers that may legally follow it, plus a count of how many of those slots are valid. A node ending in a branch lists several successors, and any one of them is accepted.

A start pulse from the monitored side sets the current node to a given entry identifier and arms the checker. Each reported identifier is compared against the valid successors of the current node. A legal identifier becomes the new current node. An illegal one raises a sticky error flag and captures the offending identifier. The reserved identifier 0xFF marks program end and is legal only from a node with no successors. A legal end returns the checker to idle.

The identifier input is a valid/ready stream. The checker never applies back-pressure: `id_ready` is high in every cycle after reset, and a beat transfers whenever `id_valid` is high. Beats that arrive while the checker is idle or halted on an error are consumed and dropped. Table writes and the start signal are plain control pins.

Top module: `cfg_checker`

## Requirements
- R1: Out of reset, `err_flag` is 0, `err_id` is 0, every successor count is 0, and the checker is idle. `id_ready` is 0 during reset and 1 in every cycle afterwards.
- R2: A `start` pulse clears `err_flag` and `err_id` to 0 and makes `entry_id` the current node, from any state. If `entry_id` is not below the node count (64), the checker instead flags an error with `err_id` = `entry_id` in the next cycle. An identifier beat in the same cycle as `start` is dropped.
- R3: While running, an identifier found among the valid successor slots of the current node is accepted without error and becomes the current node.
- R4: A node with several valid successors accepts any one of them. Different runs may take different branches.
- R5: While running, an identifier not among the valid slots sets `err_flag` and loads `err_id` with that identifier in the cycle after the beat. Identifiers stored in slots at or above the count do not count as valid.
- R6: Once set, `err_flag` and `err_id` hold until the next `start`. Later beats change neither.
- R7: Identifier 0xFF from a node whose count is 0 is legal and returns the checker to idle. Beats after that are dropped without error.
- R8: Identifier 0xFF from a node with a nonzero count is an error. Any other identifier not below the node count is an error even if it is listed as a successor.
- R9: A table write (`tbl_kind` 0 stores `tbl_data` into slot `tbl_slot` of node `tbl_node`; `tbl_kind` 1 stores the low 3 bits of `tbl_data` as that node's count) takes effect only while idle and without `start`. Otherwise it is ignored.
- R10: A stored count above 4 behaves as 4.
- R11: Beats received while idle never raise an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_kind | input | 1 | 0: successor slot, 1: successor count |
| tbl_node | input | 6 | Node index being written |
| tbl_slot | input | 2 | Slot index for a successor write |
| tbl_data | input | 8 | Successor identifier or count |
| start | input | 1 | Arm checking from the entry node |
| entry_id | input | 8 | Identifier of the entry node |
| id_valid | input | 1 | Reported identifier is valid |
| id_ready | output | 1 | Checker accepts a beat (always 1 after reset) |
| id_data | input | 8 | Reported node identifier |
| err_flag | output | 1 | Sticky control-flow error |
| err_id | output | 8 | First offending identifier |

## Verification
The assertions assume that the table is written only between runs, that `id_data` is meaningful whenever `id_valid` is high, and that `start` is a single-cycle pulse. Under these assumptions an error can only begin on a reported beat or on a start with an out-of-range entry. The stimulus loads the whole table in idle and drives starts as one-cycle pulses. It deliberately sends beats while idle, after a legal end, alongside a start, and after an error, so the dropped beats are observed at the outputs. One table write is issued mid-run, and a later run shows that it had no effect.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    CK_IDLE = 2'd0,
    CK_RUN  = 2'd1,
    CK_HALT = 2'd2
  } ck_state_t;

  typedef enum logic {
    WR_SLOT  = 1'b0,
    WR_COUNT = 1'b1
  } wr_kind_t;
endpackage

// File: rtl/cfg_succ_table.sv
module cfg_succ_table #(
  parameter int ID_W  = 8,
  parameter int NODES = 64,
  parameter int SLOTS = 4,
  parameter int CNT_W = 3,
  localparam int NW = $clog2(NODES),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_kind,
  input  logic [NW-1:0]         wr_node,
  input  logic [SW-1:0]         wr_slot,
  input  logic [ID_W-1:0]       wr_data,
  input  logic [NW-1:0]         rd_node,
  output logic [SLOTS*ID_W-1:0] rd_ids,
  output logic [CNT_W-1:0]      rd_cnt
);
  import cfg_pkg::*;

  logic [ID_W-1:0]  ids_q [NODES][SLOTS];
  logic [CNT_W-1:0] cnt_q [NODES];

  // successor identifiers carry no reset: a zero count hides them
  always_ff @(posedge clk) begin
    if (wr_en && wr_kind == WR_SLOT)
      ids_q[wr_node][wr_slot] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NODES; n++) cnt_q[n] <= '0;
    end else if (wr_en && wr_kind == WR_COUNT) begin
      cnt_q[wr_node] <= wr_data[CNT_W-1:0];
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    assign rd_ids[s*ID_W +: ID_W] = ids_q[rd_node][s];
  end

  assign rd_cnt = cnt_q[rd_node];
endmodule

// File: rtl/cfg_succ_match.sv
module cfg_succ_match #(
  parameter int ID_W  = 8,
  parameter int SLOTS = 4,
  parameter int CNT_W = 3
) (
  input  logic [SLOTS*ID_W-1:0] ids,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [ID_W-1:0]       probe,
  output logic                  hit,
  output logic                  empty
);
  localparam int CLAMP_W = (CNT_W > 31) ? 32 : CNT_W + 1;

  logic [CLAMP_W-1:0] eff_cnt;
  logic [SLOTS-1:0]   slot_hit;

  // counts beyond the slot capacity saturate at the capacity
  always_comb begin
    if (CLAMP_W'(cnt) > CLAMP_W'(SLOTS)) eff_cnt = CLAMP_W'(SLOTS);
    else                                 eff_cnt = CLAMP_W'(cnt);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign slot_hit[s] = (32'(eff_cnt) > s) && (ids[s*ID_W +: ID_W] == probe);
  end

  assign hit   = |slot_hit;
  assign empty = (cnt == '0);
endmodule

// File: rtl/cfg_checker.sv
module cfg_checker #(
  parameter int ID_W  = 8,
  parameter int NODES = 64,
  parameter int SLOTS = 4,
  parameter int CNT_W = 3,
  localparam int NW = $clog2(NODES),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_we,
  input  logic            tbl_kind,
  input  logic [NW-1:0]   tbl_node,
  input  logic [SW-1:0]   tbl_slot,
  input  logic [ID_W-1:0] tbl_data,
  input  logic            start,
  input  logic [ID_W-1:0] entry_id,
  input  logic            id_valid,
  output logic            id_ready,
  input  logic [ID_W-1:0] id_data,
  output logic            err_flag,
  output logic [ID_W-1:0] err_id
);
  import cfg_pkg::*;

  localparam logic [ID_W-1:0] END_ID = '1;

  ck_state_t              state_q;
  logic [NW-1:0]          cur_q;
  logic                   ready_q;
  logic                   err_q;
  logic [ID_W-1:0]        eid_q;
  logic [SLOTS*ID_W-1:0]  succ_ids;
  logic [CNT_W-1:0]       succ_cnt;
  logic                   succ_hit;
  logic                   succ_empty;
  logic                   tbl_wr_ok;
  logic                   beat;
  logic                   is_end;
  logic                   id_in_range;
  logic                   entry_in_range;
  logic                   legal;

  assign tbl_wr_ok = tbl_we && (state_q == CK_IDLE) && !start;

  cfg_succ_table #(
    .ID_W(ID_W), .NODES(NODES), .SLOTS(SLOTS), .CNT_W(CNT_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_ok),
    .wr_kind (tbl_kind),
    .wr_node (tbl_node),
    .wr_slot (tbl_slot),
    .wr_data (tbl_data),
    .rd_node (cur_q),
    .rd_ids  (succ_ids),
    .rd_cnt  (succ_cnt)
  );

  cfg_succ_match #(
    .ID_W(ID_W), .SLOTS(SLOTS), .CNT_W(CNT_W)
  ) u_match (
    .ids   (succ_ids),
    .cnt   (succ_cnt),
    .probe (id_data),
    .hit   (succ_hit),
    .empty (succ_empty)
  );

  assign beat           = id_valid && id_ready && (state_q == CK_RUN);
  assign is_end         = (id_data == END_ID);
  assign id_in_range    = (32'(id_data) < NODES);
  assign entry_in_range = (32'(entry_id) < NODES);
  assign legal          = is_end ? succ_empty : (succ_hit && id_in_range);

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CK_IDLE;
      cur_q   <= '0;
      err_q   <= 1'b0;
      eid_q   <= '0;
    end else if (start) begin
      cur_q <= entry_id[NW-1:0];
      if (entry_in_range) begin
        state_q <= CK_RUN;
        err_q   <= 1'b0;
        eid_q   <= '0;
      end else begin
        state_q <= CK_HALT;
        err_q   <= 1'b1;
        eid_q   <= entry_id;
      end
    end else if (beat) begin
      if (!legal) begin
        state_q <= CK_HALT;
        err_q   <= 1'b1;
        eid_q   <= id_data;
      end else if (is_end) begin
        state_q <= CK_IDLE;
      end else begin
        cur_q <= id_data[NW-1:0];
      end
    end
  end

  assign id_ready = ready_q;
  assign err_flag = err_q;
  assign err_id   = eid_q;
endmodule

// File: rtl/cfg_checker_sva.sv
module cfg_checker_sva #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            id_valid,
  input logic [ID_W-1:0] id_data,
  input logic [ID_W-1:0] entry_id,
  input logic            id_ready,
  input logic            err_flag,
  input logic [ID_W-1:0] err_id
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !start |=> err_flag); // R6

  AST_ERRID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !start |=> $stable(err_id)); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!err_flag || err_id == $past(entry_id))); // R2

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> ($past(start) ? err_id == $past(entry_id)
                                      : ($past(id_valid) && err_id == $past(id_data)))); // R5

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> id_ready); // R1
endmodule

bind cfg_checker cfg_checker_sva #(.ID_W(ID_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .id_valid (id_valid),
  .id_data  (id_data),
  .entry_id (entry_id),
  .id_ready (id_ready),
  .err_flag (err_flag),
  .err_id   (err_id)
);

// File: tb/cfg_checker_test.sv
module cfg_checker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic       tbl_kind = 1'b0;
  logic [5:0] tbl_node = '0;
  logic [1:0] tbl_slot = '0;
  logic [7:0] tbl_data = '0;
  logic       start = 1'b0;
  logic [7:0] entry_id = '0;
  logic       id_valid = 1'b0;
  logic [7:0] id_data = '0;
  logic       id_ready;
  logic       err_flag;
  logic [7:0] err_id;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference
  int m_cnt [64];
  int m_succ [64][4];
  int m_mode = 0;      // 0 idle, 1 running, 2 halted
  int m_cur = 0;
  bit m_err = 0;
  int m_eid = 0;
  bit m_rdy = 0;

  always #4 clk = ~clk;

  cfg_checker uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_kind(tbl_kind),
    .tbl_node(tbl_node), .tbl_slot(tbl_slot), .tbl_data(tbl_data),
    .start(start), .entry_id(entry_id), .id_valid(id_valid),
    .id_ready(id_ready), .id_data(id_data), .err_flag(err_flag), .err_id(err_id)
  );

  task automatic model_edge();
    if (!rst_n) begin
      foreach (m_cnt[n]) m_cnt[n] = 0;
      m_mode = 0; m_cur = 0; m_err = 0; m_eid = 0; m_rdy = 0;
      return;
    end
    if (tbl_we && m_mode == 0 && !start) begin
      if (tbl_kind) m_cnt[tbl_node] = int'(tbl_data) % 8;
      else          m_succ[tbl_node][tbl_slot] = int'(tbl_data);
    end
    if (start) begin
      m_cur = int'(entry_id) % 64;
      if (entry_id < 64) begin m_mode = 1; m_err = 0; m_eid = 0; end
      else begin m_mode = 2; m_err = 1; m_eid = int'(entry_id); end
    end else if (id_valid && m_rdy && m_mode == 1) begin
      int allowed [$];
      int lim = (m_cnt[m_cur] > 4) ? 4 : m_cnt[m_cur];
      bit ok;
      for (int k = 0; k < lim; k++) allowed.push_back(m_succ[m_cur][k]);
      if (id_data == 8'hFF) ok = (m_cnt[m_cur] == 0);
      else ok = (id_data < 64) && (allowed.size() > 0) &&
                (allowed.find_first_index(x) with (x == int'(id_data)) .size() > 0);
      if (!ok) begin m_mode = 2; m_err = 1; m_eid = int'(id_data); end
      else if (id_data == 8'hFF) m_mode = 0;
      else m_cur = int'(id_data);
    end
    m_rdy = 1;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    #2;
    if (!done) begin
      vectors++;
      if (err_flag !== m_err || err_id !== 8'(m_eid) || id_ready !== m_rdy) begin
        fails++;
        $display("FAIL %s: err_flag=%0b err_id=%0d ready=%0b expected %0b %0d %0b",
                 tag, err_flag, err_id, id_ready, m_err, m_eid, m_rdy);
      end
    end
    start = 0; tbl_we = 0; id_valid = 0;
  endtask

  task automatic wr(input bit kind, input int node, input int slot, input int data);
    tbl_we = 1; tbl_kind = kind; tbl_node = 6'(node); tbl_slot = 2'(slot); tbl_data = 8'(data);
    tick("R9");
  endtask

  task automatic go(input int entry, input string tag);
    start = 1; entry_id = 8'(entry);
    tick(tag);
  endtask

  task automatic send(input int id, input string tag);
    id_valid = 1; id_data = 8'(id);
    tick(tag);
    tick(tag);  // an idle gap between beats
  endtask

  task automatic expect_out(input bit e, input int id, input string tag);
    vectors++;
    if (err_flag !== e || err_id !== 8'(id)) begin
      fails++;
      $display("FAIL %s: err_flag=%0b err_id=%0d expected %0b %0d", tag, err_flag, err_id, e, id);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick("R1");
    rst_n = 1;
    tick("R1");
    expect_out(0, 0, "R1");
    // R11: beats while idle are dropped
    send(5, "R11");
    expect_out(0, 0, "R11");
    // table: 1->{2}; 2->{3,5}; 3->{6}; 5->{6}; 6 end; 7 count 6 slots 8..11; 11 end
    // 4 count 2 slots {2,3,12,12}; 9 -> {70}
    wr(1, 1, 0, 1); wr(0, 1, 0, 2);
    wr(1, 2, 0, 2); wr(0, 2, 0, 3); wr(0, 2, 1, 5);
    wr(1, 3, 0, 1); wr(0, 3, 0, 6);
    wr(1, 5, 0, 1); wr(0, 5, 0, 6);
    for (int s = 0; s < 4; s++) wr(0, 7, s, 8 + s);
    wr(1, 7, 0, 6);
    wr(1, 4, 0, 2); wr(0, 4, 0, 2); wr(0, 4, 1, 3); wr(0, 4, 2, 12); wr(0, 4, 3, 12);
    wr(1, 9, 0, 1); wr(0, 9, 0, 70);
    // R3, R7: straight path to a legal end
    go(1, "R3");
    send(2, "R3"); send(3, "R3"); send(6, "R3"); send(255, "R7");
    expect_out(0, 0, "R7");
    send(40, "R7");
    expect_out(0, 0, "R7");
    // R4: the other branch from node 2
    go(1, "R4");
    send(2, "R4"); send(5, "R4"); send(6, "R4"); send(255, "R4");
    expect_out(0, 0, "R4");
    // R5, R6: illegal successor, then later beats ignored
    go(1, "R5");
    send(2, "R5"); send(4, "R5");
    expect_out(1, 4, "R5");
    send(3, "R6"); send(7, "R6");
    expect_out(1, 4, "R6");
    // R2: start clears; beat with start dropped; R8 end from counted node
    id_valid = 1; id_data = 8'd9;
    go(2, "R2");
    expect_out(0, 0, "R2");
    send(3, "R8"); send(255, "R8");
    expect_out(1, 255, "R8");
    // R9: write during a run is ignored
    go(1, "R9");
    wr(1, 1, 0, 0);
    send(2, "R9"); send(3, "R9"); send(6, "R9"); send(255, "R9");
    go(1, "R9");
    send(255, "R9");
    expect_out(1, 255, "R9");
    // R10: count 6 acts as 4
    go(7, "R10");
    send(11, "R10"); send(255, "R10");
    expect_out(0, 0, "R10");
    // R5: slot beyond the count
    go(4, "R5");
    send(12, "R5");
    expect_out(1, 12, "R5");
    // R8: listed but out-of-range identifier
    go(9, "R8");
    send(70, "R8");
    expect_out(1, 70, "R8");
    // R2: out-of-range entry
    go(200, "R2");
    expect_out(1, 200, "R2");
    tick("R2");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule